// File: doc/BRIEF.md
# Two-Group Latched Rail Sequencer

This block brings up four power rails, named A, B, C and D, as two pairs. A and B form the first group and C and D form the second. Each group has its own active-low enable and its own active-low reset output. Power-up needs both enables asserted and all four under-voltage monitors reporting good. These conditions must then hold for a qualification window counted in ticks. After that the gates turn on strictly in the order A, B, C, D. Each gate waits for its own programmable on-delay. That delay is counted from the moment the gate before it reports fully on. Once rail D reports fully on, both reset outputs are released after a fixed hold time.

A monitor that drops out on a running group is treated as a fault. The fault takes down only that group's gates and reset, and the fault is latched. The group stays off until its own enable is released and then asserted again. Releasing a group's enable shuts that group down in reverse order. Each gate waits for its own off-delay, and the next off-delay starts only when the previous gate reports low. All delays are counted in units of the `tick` strobe.

Top module: `rail_seq2`

## Requirements
- R1: After reset, all four gate enables are low and both reset outputs are low.
- R2: No gate turns on unless `en_n` is 2'b00 and `uvlo_ok` is 4'b1111, and these have held for QUAL_TICKS consecutive ticks. Gate A then follows its on-delay.
- R3: Gates turn on in the order A, B, C, D (bit 0 to bit 3 of `gate_en`). Each gate after A asserts its on-delay ticks after the preceding gate's `gate_on` bit rises. Any set of delay values leaves this order unchanged.
- R4: A channel with an on-delay of 0 asserts its gate within a few cycles of its start condition, with no tick spent waiting.
- R5: Both `rst_n_o` bits go high RST_TICKS ticks after `gate_on[3]` rises. A reset bit is high only while both gates of its group were on in the previous cycle.
- R6: A low `uvlo_ok` bit in a running group drops that group's two gates on the next clock edge and its reset output one edge later. The other group's gates and reset do not change. Bits 1:0 belong to group A/B and bits 3:2 to group C/D.
- R7: A faulted group stays off even after its monitors recover and both enables are asserted. A rising edge on its `en_n` bit clears the fault. After a new qualification the group restarts, and C/D starts once A/B is up.
- R8: Raising a group's `en_n` bit drops its reset output. The group's later gate turns off after its off-delay. The earlier gate turns off only after the later gate's `gate_low` bit is set and its own off-delay has elapsed.
- R9: A low `uvlo_ok` bit while both groups are idle latches nothing. Restoring it lets a normal power-up complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base strobe; all delays count these |
| en_n | input | 2 | Active-low enables, bit 0 group A/B, bit 1 group C/D |
| uvlo_ok | input | 4 | Rail monitor good flags, bit i for channel i (A=0..D=3) |
| gate_on | input | 4 | Gate fully-on status per channel |
| gate_low | input | 4 | Gate discharged status per channel |
| on_dly | input | 4*DLY_W | Per-channel on-delay in ticks, channel i at [i*DLY_W +: DLY_W] |
| off_dly | input | 4*DLY_W | Per-channel off-delay in ticks, same packing |
| gate_en | output | 4 | Gate drive enables, bit i for channel i |
| rst_n_o | output | 2 | Active-low reset per group, bit 0 A/B, bit 1 C/D |

## Verification
The bench starts with a partial enable and with one monitor held low. A design that sequenced on a single enable, or on a stale qualification count, would raise gate A in those windows. Random delay sets, including all-zero sets, are run through full power cycles. Every gate-to-gate interval is measured, so a counter that starts at the wrong event or gets the order wrong shows up as an interval outside its window. A fault on group C/D must leave A/B running, and C/D must stay dark until its enable toggles. A design that shut down both groups, or auto-restarted, fails there. On shutdown the bench checks that a gate falls only after its successor has reported low.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [3:0] {
    GS_OFF, GS_DLY0, GS_WAIT0, GS_DLY1, GS_WAIT1, GS_UP,
    GS_SDLY1, GS_SWAIT1, GS_SDLY0, GS_SWAIT0, GS_FLT
  } grp_st_t;
endpackage

// File: rtl/seq_qual.sv
module seq_qual #(
  parameter int QUAL_TICKS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic cond,
  output logic go
);
  localparam int CW = $clog2(QUAL_TICKS + 1);
  localparam logic [CW-1:0] LIM = CW'(QUAL_TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !cond) cnt <= '0;
    else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign go = cond && (cnt == LIM);
endmodule

// File: rtl/seq_rtmr.sv
module seq_rtmr #(
  parameter int RST_TICKS = 160
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(RST_TICKS + 1);
  localparam logic [CW-1:0] LIM = CW'(RST_TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LIM);
endmodule

// File: rtl/seq_group.sv
module seq_group
  import seq_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               en,
  input  logic               en_rise,
  input  logic               start,
  input  logic [1:0]         uv_ok,
  input  logic [1:0]         g_on,
  input  logic [1:0]         g_low,
  input  logic [2*DLY_W-1:0] on_d,
  input  logic [2*DLY_W-1:0] off_d,
  output logic [1:0]         gate,
  output logic               up
);
  grp_st_t          st;
  logic [DLY_W-1:0] cnt;
  logic [DLY_W-1:0] d_on0, d_on1, d_off0, d_off1;
  logic             live, run_phase, fault;

  assign d_on0  = on_d[0 +: DLY_W];
  assign d_on1  = on_d[DLY_W +: DLY_W];
  assign d_off0 = off_d[0 +: DLY_W];
  assign d_off1 = off_d[DLY_W +: DLY_W];

  always_comb begin
    live      = (st != GS_OFF) && (st != GS_FLT);
    run_phase = st inside {GS_DLY0, GS_WAIT0, GS_DLY1, GS_WAIT1, GS_UP};
    fault     = live && !(&uv_ok);
  end

  assign up = (st == GS_UP);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= GS_OFF;
      cnt  <= '0;
      gate <= '0;
    end else if (st == GS_OFF) begin
      cnt <= '0;
      if (start && en) st <= GS_DLY0;
    end else if (st == GS_FLT) begin
      gate <= '0;
      if (en_rise) st <= GS_OFF;
    end else if (fault) begin
      st   <= GS_FLT;
      gate <= '0;
    end else if (!en && run_phase) begin
      cnt <= '0;
      if (gate[1])      st <= GS_SDLY1;
      else if (gate[0]) st <= GS_SDLY0;
      else              st <= GS_OFF;
    end else begin
      case (st)
        GS_DLY0:
          if (cnt == d_on0) begin gate[0] <= 1'b1; st <= GS_WAIT0; end
          else if (tick) cnt <= cnt + 1'b1;
        GS_WAIT0:
          if (g_on[0]) begin st <= GS_DLY1; cnt <= '0; end
        GS_DLY1:
          if (cnt == d_on1) begin gate[1] <= 1'b1; st <= GS_WAIT1; end
          else if (tick) cnt <= cnt + 1'b1;
        GS_WAIT1:
          if (g_on[1]) st <= GS_UP;
        GS_SDLY1:
          if (cnt == d_off1) begin gate[1] <= 1'b0; st <= GS_SWAIT1; end
          else if (tick) cnt <= cnt + 1'b1;
        GS_SWAIT1:
          if (g_low[1]) begin st <= GS_SDLY0; cnt <= '0; end
        GS_SDLY0:
          if (cnt == d_off0) begin gate[0] <= 1'b0; st <= GS_SWAIT0; end
          else if (tick) cnt <= cnt + 1'b1;
        GS_SWAIT0:
          if (g_low[0]) st <= GS_OFF;
        default: ;
      endcase
    end
  end

  // R3: the second gate of a group never rises before the first
  a_r3_pair_order: assert property (@(posedge clk) disable iff (rst)
    $rose(gate[1]) |-> gate[0]);

  // R8: the first gate never drops while the second is still driven
  a_r8_reverse_off: assert property (@(posedge clk) disable iff (rst)
    $fell(gate[0]) |-> !gate[1]);

  // R7: a latched fault keeps both gates off
  a_r7_fault_dark: assert property (@(posedge clk) disable iff (rst)
    (st == GS_FLT) |=> (gate == 2'b00));

  // R6: a monitor dropout on a live group clears its gates on the next edge
  a_r6_fault_drop: assert property (@(posedge clk) disable iff (rst)
    (live && !(&uv_ok)) |=> (gate == 2'b00));
endmodule

// File: rtl/rail_seq2.sv
module rail_seq2 #(
  parameter int DLY_W      = 8,
  parameter int QUAL_TICKS = 10,
  parameter int RST_TICKS  = 160
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [1:0]         en_n,
  input  logic [3:0]         uvlo_ok,
  input  logic [3:0]         gate_on,
  input  logic [3:0]         gate_low,
  input  logic [4*DLY_W-1:0] on_dly,
  input  logic [4*DLY_W-1:0] off_dly,
  output logic [3:0]         gate_en,
  output logic [1:0]         rst_n_o
);
  localparam int NGRP = 2;
  localparam int GW   = 2 * DLY_W;

  logic [NGRP-1:0] en_n_q, en_rise, start, up;
  logic            go, rls;

  always_ff @(posedge clk) begin
    if (rst) en_n_q <= '1;
    else     en_n_q <= en_n;
  end
  assign en_rise = en_n & ~en_n_q;

  seq_qual #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
    .clk(clk), .rst(rst), .tick(tick),
    .cond((~|en_n) && (&uvlo_ok)), .go(go)
  );

  seq_rtmr #(.RST_TICKS(RST_TICKS)) u_rtmr (
    .clk(clk), .rst(rst), .tick(tick), .run(&up), .done(rls)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    if (g == 0) begin : g_first
      assign start[g] = go;
    end else begin : g_next
      assign start[g] = go && up[g-1];
    end

    seq_group #(.DLY_W(DLY_W)) u_grp (
      .clk(clk), .rst(rst), .tick(tick),
      .en(!en_n[g]), .en_rise(en_rise[g]), .start(start[g]),
      .uv_ok(uvlo_ok[2*g +: 2]), .g_on(gate_on[2*g +: 2]),
      .g_low(gate_low[2*g +: 2]),
      .on_d(on_dly[g*GW +: GW]), .off_d(off_dly[g*GW +: GW]),
      .gate(gate_en[2*g +: 2]), .up(up[g])
    );

    always_ff @(posedge clk) begin
      if (rst || !up[g]) rst_n_o[g] <= 1'b0;
      else if (rls)      rst_n_o[g] <= 1'b1;
    end

    // R5: a released reset implies both gates of its group were on
    a_r5_rst_gates: assert property (@(posedge clk) disable iff (rst)
      rst_n_o[g] |-> $past(gate_en[2*g] && gate_en[2*g+1]));
  end

  // R2: gate A only rises with its group enabled and its monitors good
  a_r2_start_cond: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_en[0]) |-> $past(!en_n[0] && (&uvlo_ok[1:0])));

  // R1: outputs are quiet in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (gate_en == 4'b0000 && rst_n_o == 2'b00));
endmodule

// File: tb/sim_rail_seq2.sv
module sim_rail_seq2;
  localparam int CLK_P = 10;
  localparam int DW    = 8;
  localparam int QT    = 10;
  localparam int RT    = 160;

  logic          clk = 1'b0, rst = 1'b1, tick = 1'b1;
  logic [1:0]    en_n = 2'b11;
  logic [3:0]    uvlo_ok = 4'b1111, gate_on = 4'b0, gate_low = 4'b1111;
  logic [4*DW-1:0] on_dly = '0, off_dly = '0;
  logic [3:0]    gate_en;
  logic [1:0]    rst_n_o;

  rail_seq2 #(.DLY_W(DW), .QUAL_TICKS(QT), .RST_TICKS(RT)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .en_n(en_n), .uvlo_ok(uvlo_ok),
    .gate_on(gate_on), .gate_low(gate_low), .on_dly(on_dly),
    .off_dly(off_dly), .gate_en(gate_en), .rst_n_o(rst_n_o)
  );

  always #(CLK_P/2) clk = ~clk;

  int cyc = 0, n_chk = 0, n_fail = 0;
  int t_er[4], t_ef[4], t_on[4], t_lo[4], t_rr[2], t_rf[2];
  int dn[4], df[4];
  int pc_on[4], pc_lo[4];
  logic [3:0] ge_q = 4'b0;
  logic [1:0] rn_q = 2'b0;
  bit done_flag = 0;

  initial forever @(posedge clk) cyc++;

  // monitor then gate plant (3-cycle rise/fall), both at negedge
  initial forever begin
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      if (gate_en[i] && !ge_q[i]) t_er[i] = cyc;
      if (!gate_en[i] && ge_q[i]) t_ef[i] = cyc;
      pc_on[i] = gate_en[i] ? pc_on[i] + 1 : 0;
      pc_lo[i] = gate_en[i] ? 0 : pc_lo[i] + 1;
      if (pc_on[i] >= 3 && !gate_on[i]) begin gate_on[i] = 1'b1; t_on[i] = cyc; end
      if (pc_on[i] < 3) gate_on[i] = 1'b0;
      if (pc_lo[i] >= 3 && !gate_low[i]) begin gate_low[i] = 1'b1; t_lo[i] = cyc; end
      if (pc_lo[i] < 3) gate_low[i] = 1'b0;
    end
    for (int g = 0; g < 2; g++) begin
      if (rst_n_o[g] && !rn_q[g]) t_rr[g] = cyc;
      if (!rst_n_o[g] && rn_q[g]) t_rf[g] = cyc;
    end
    ge_q = gate_en;
    rn_q = rst_n_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit in_win(input int v, input int lo, input int hi);
    return (v >= lo) && (v <= hi);
  endfunction

  task automatic load_dly();
    for (int i = 0; i < 4; i++) begin
      on_dly[i*DW +: DW]  = DW'(dn[i]);
      off_dly[i*DW +: DW] = DW'(df[i]);
    end
  endtask

  task automatic power_up(input bit zero_chk);
    int t0;
    load_dly();
    @(negedge clk);
    t0 = cyc;
    en_n = 2'b00;
    for (int k = 0; k < 4000 && rst_n_o != 2'b11; k++) @(negedge clk);
    chk(rst_n_o == 2'b11, "R5 reset release", rst_n_o, 3);
    chk(in_win(t_er[0] - t0, QT + dn[0], QT + dn[0] + 4), "R2 gate A after qualification",
        t_er[0] - t0, QT + dn[0]);
    for (int i = 1; i < 4; i++) begin
      chk(t_er[i] > t_er[i-1], "R3 turn-on order", t_er[i], t_er[i-1] + 1);
      chk(in_win(t_er[i] - t_on[i-1], dn[i], dn[i] + 4), "R3 on-delay from prior gate on",
          t_er[i] - t_on[i-1], dn[i]);
    end
    if (zero_chk)
      chk(t_er[0] - t0 <= QT + 3, "R4 zero delay start", t_er[0] - t0, QT);
    for (int g = 0; g < 2; g++)
      chk(in_win(t_rr[g] - t_on[3], RT, RT + 4), "R5 reset hold time", t_rr[g] - t_on[3], RT);
  endtask

  task automatic power_down();
    int t0;
    @(negedge clk);
    t0 = cyc;
    en_n = 2'b11;
    for (int k = 0; k < 4000 && gate_low != 4'b1111; k++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(gate_en == 4'b0000, "R8 all gates off", gate_en, 0);
    for (int g = 0; g < 2; g++) begin
      chk(t_rf[g] - t0 <= 3, "R8 reset drops on disable", t_rf[g] - t0, 2);
      chk(t_ef[2*g+1] - t0 >= df[2*g+1], "R8 later gate off-delay",
          t_ef[2*g+1] - t0, df[2*g+1]);
      chk(t_ef[2*g] - t_lo[2*g+1] >= df[2*g], "R8 earlier gate waits for later low",
          t_ef[2*g] - t_lo[2*g+1], df[2*g]);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin dn[i] = 2; df[i] = 2; pc_on[i] = 0; pc_lo[i] = 10; end
    load_dly();
    repeat (4) @(negedge clk);
    chk(gate_en == 4'b0000, "R1 gates after reset", gate_en, 0);
    chk(rst_n_o == 2'b00, "R1 resets after reset", rst_n_o, 0);
    rst = 1'b0;

    // R2: only group A/B enabled
    en_n = 2'b10;
    repeat (100) @(negedge clk);
    chk(gate_en == 4'b0000, "R2 partial enable no start", gate_en, 0);

    // R9 / R2: monitor low while idle, then restored
    en_n = 2'b11;
    repeat (3) @(negedge clk);
    uvlo_ok = 4'b1110;
    en_n = 2'b00;
    repeat (60) @(negedge clk);
    chk(gate_en == 4'b0000, "R2 monitor low no start", gate_en, 0);
    en_n = 2'b11;
    uvlo_ok = 4'b1111;
    repeat (3) @(negedge clk);
    power_up(1'b0);
    chk(gate_en == 4'b1111, "R9 idle dropout not latched", gate_en, 15);

    // R6 / R7: fault on group C/D
    @(negedge clk);
    uvlo_ok = 4'b1011;
    repeat (3) @(negedge clk);
    chk(gate_en[3:2] == 2'b00, "R6 faulted group gates off", gate_en[3:2], 0);
    chk(rst_n_o[1] == 1'b0, "R6 faulted group reset low", rst_n_o[1], 0);
    chk(gate_en[1:0] == 2'b11, "R6 other group gates kept", gate_en[1:0], 3);
    chk(rst_n_o[0] == 1'b1, "R6 other group reset kept", rst_n_o[0], 1);
    uvlo_ok = 4'b1111;
    repeat (80) @(negedge clk);
    chk(gate_en[3:2] == 2'b00, "R7 fault stays latched", gate_en[3:2], 0);
    en_n[1] = 1'b1;
    repeat (5) @(negedge clk);
    en_n[1] = 1'b0;
    for (int k = 0; k < 4000 && rst_n_o != 2'b11; k++) @(negedge clk);
    chk(gate_en == 4'b1111, "R7 restart after enable cycle", gate_en, 15);
    chk(rst_n_o == 2'b11, "R7 reset back after restart", rst_n_o, 3);
    power_down();

    // R4: all zero delays
    for (int i = 0; i < 4; i++) begin dn[i] = 0; df[i] = 0; end
    power_up(1'b1);
    power_down();

    // R3 / R8: random delay sets
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < 4; i++) begin
        dn[i] = $urandom_range(0, 9);
        df[i] = $urandom_range(0, 9);
      end
      power_up(1'b0);
      power_down();
    end

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1..all actual=%0d expected=finished", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule